// File: doc/BRIEF.md
# Extended Capability List Walker

This block maintains the chain of extended capability headers that lives in the upper part of a 4 KB configuration space. It reaches that space only through a dword-wide memory port with a one-cycle read latency. A plane select on the port picks one of four parallel arrays: the configuration data itself, the write-enable mask, the write-1-to-clear mask and the check mask.

Every header dword carries a 16-bit capability ID in bits 15:0, a 4-bit version in bits 19:16 and a 12-bit byte pointer to the next header in bits 31:20. The chain always starts at byte offset 0x100. A zero pointer ends it.

A find command walks the chain looking for an ID. It returns the byte offset of the matching header and the offset of the header visited just before it. An append command links a new header onto the chain. It then makes the new region read-only by clearing its write-enable and write-1-to-clear masks, and it sets its check mask to all ones. Only one command runs at a time, under a start/busy/done handshake.

Top module: `ecap_walker`

## Requirements
- R1: A find while the dword at 0x100 is all zeros finishes with match offset 0, previous offset 0 and no error.
- R2: A find for a non-zero ID that equals a header's ID returns that header's byte offset as the match offset. The previous offset is the header visited just before it, or 0 when the match is at 0x100.
- R3: A find for an ID that is absent returns match offset 0, with the last header of the chain (the one whose pointer is zero) as the previous offset.
- R4: ID 0 never matches, so finding it reports the chain's last header as the previous offset and 0 as the match offset.
- R5: A find never writes to any plane of the memory port (plane 0 config, 1 write-enable mask, 2 write-1-to-clear mask, 3 check mask).
- R6: Following a pointer below 0x100, above 0xFF8 or with bits 1:0 not zero ends the command with the error flag set in the same cycle as the done pulse.
- R7: A chain that visits more than MAX_STEPS headers, for instance one that loops back on itself, ends with the error flag set.
- R8: Appending at 0x100 writes the new ID and version there and keeps the pointer field that was already stored at 0x100.
- R9: Appending at any other offset changes only bits 31:20 of the last header, which become the new offset. It then writes the new header with a zero pointer, so a later find of the new ID returns the new offset with the old tail as the previous offset.
- R10: An append is refused with the error flag and no memory write when the offset is below 0x100, is not a multiple of 4, the size is below 8 bytes, or offset plus size reaches 0x1000. It is also refused when the chain is empty and the offset is not 0x100.
- R11: After an append, every byte of the region [offset, offset+size) reads 0x00 in planes 1 and 2 and 0xFF in plane 3. Bytes of the last dword beyond the region are left untouched.
- R12: busy rises the cycle after start is accepted. done is a one-cycle pulse given in the cycle busy falls. A start while busy is ignored and yields no extra done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Accept a command when idle |
| cmd_op | input | 1 | 0 find, 1 append |
| cmd_id | input | 16 | Capability ID |
| cmd_ver | input | 4 | Version for append |
| cmd_off | input | 12 | Byte offset for append |
| cmd_size | input | SIZE_W | Region size in bytes for append |
| busy | output | 1 | Command in flight |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last command failed |
| match_off | output | 12 | Byte offset of the matching header, or 0 |
| prev_off | output | 12 | Byte offset of the header visited before it |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_plane | output | 2 | Array select: 0 config, 1 write mask, 2 write-1-to-clear mask, 3 check mask |
| mem_addr | output | 10 | Dword address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
The bench works on a chain of three headers. Finding each ID confirms the previous-offset bookkeeping; a design that returns the current node instead of the earlier one shows wrong prev values. Finding ID 0 and an absent ID shows whether the tail is taken from the last header or from one step too far.

Bad pointers are tried: one misaligned, one below 0x100 and one above 0xFF8. So is a self-loop, which a design without a step bound would walk forever.

Appends are tried at 0x100 with a stored pointer, which a careless design would zero. They are also tried in the middle of the space with a size that is not a multiple of four, where a wrong tail byte mask would corrupt the bytes beyond the region. Refused appends and a start issued while busy are checked by counting memory writes and done pulses.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

  localparam int CFG_AW    = 12;
  localparam int DW_AW     = CFG_AW - 2;
  localparam int CFG_BYTES = 1 << CFG_AW;

  localparam logic [CFG_AW-1:0] LIST_HEAD = 12'h100;
  localparam logic [CFG_AW-1:0] PTR_LAST  = 12'hFF8;
  localparam logic [DW_AW-1:0]  HEAD_DW   = LIST_HEAD[CFG_AW-1:2];

  typedef enum logic [1:0] {
    PL_CFG   = 2'd0,
    PL_WMASK = 2'd1,
    PL_W1C   = 2'd2,
    PL_CHECK = 2'd3
  } plane_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WAIT,
    ST_DATA,
    ST_NEWHDR,
    ST_FILL,
    ST_FIN
  } walk_state_e;

  typedef struct packed {
    logic [11:0] nxt;
    logic [3:0]  ver;
    logic [15:0] id;
  } hdr_t;

endpackage

// File: rtl/ecap_ptr_check.sv
module ecap_ptr_check
  import ecap_pkg::*;
(
  input  logic [CFG_AW-1:0] ptr,
  output logic              ok
);

  logic in_low;
  logic in_high;
  logic aligned;

  assign in_low  = (ptr >= LIST_HEAD);
  assign in_high = (ptr <= PTR_LAST);
  assign aligned = (ptr[1:0] == 2'b00);
  assign ok      = in_low && in_high && aligned;

endmodule

// File: rtl/ecap_region_calc.sv
module ecap_region_calc
  import ecap_pkg::*;
#(
  parameter int SIZE_W = 13
) (
  input  logic [CFG_AW-1:0] base,
  input  logic [SIZE_W-1:0] len,
  output logic              ok,
  output logic [DW_AW-1:0]  first_dw,
  output logic [SIZE_W-1:0] n_dw,
  output logic [3:0]        tail_be
);

  localparam int EW = ((SIZE_W > CFG_AW) ? SIZE_W : CFG_AW) + 1;

  logic [EW-1:0] end_b;
  logic [EW-1:0] rounded;

  assign end_b    = EW'(base) + EW'(len);
  assign rounded  = EW'(len) + EW'(3);
  assign n_dw     = SIZE_W'(rounded >> 2);
  assign first_dw = base[CFG_AW-1:2];

  assign ok = (base >= LIST_HEAD) && (base[1:0] == 2'b00) &&
              (len >= SIZE_W'(8)) && (end_b < EW'(CFG_BYTES));

  for (genvar b = 0; b < 4; b++) begin : g_tail_be
    assign tail_be[b] = (len[1:0] == 2'b00) || (2'(b) < len[1:0]);
  end

endmodule

// File: rtl/ecap_walker.sv
module ecap_walker
  import ecap_pkg::*;
#(
  parameter int MAX_STEPS = 1024,
  parameter int SIZE_W    = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              cmd_op,
  input  logic [15:0]       cmd_id,
  input  logic [3:0]        cmd_ver,
  input  logic [11:0]       cmd_off,
  input  logic [SIZE_W-1:0] cmd_size,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [11:0]       match_off,
  output logic [11:0]       prev_off,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_plane,
  output logic [9:0]        mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);

  localparam int STEP_W = $clog2(MAX_STEPS + 1);

  walk_state_e       state;
  plane_e            plane_q;
  logic              op_q;
  logic [15:0]       id_q;
  logic [3:0]        ver_q;
  logic [11:0]       off_q;
  logic [SIZE_W-1:0] size_q;
  logic [11:0]       cur_q;
  logic [11:0]       prv_q;
  logic              head_q;
  logic [STEP_W-1:0] steps_q;
  logic [SIZE_W-1:0] dw_q;

  logic              busy_q, done_q, err_q;
  logic [11:0]       match_q, prev_q;
  logic              mem_req_q, mem_we_q;
  logic [1:0]        mem_plane_q;
  logic [DW_AW-1:0]  mem_addr_q;
  logic [3:0]        mem_be_q;
  logic [31:0]       mem_wdata_q;

  hdr_t              rd_hdr;
  logic              nxt_ok;
  logic              reg_ok;
  logic [DW_AW-1:0]  reg_first;
  logic [SIZE_W-1:0] reg_cnt;
  logic [3:0]        reg_tail_be;
  logic              hit;
  logic              last_dw;

  assign rd_hdr  = hdr_t'(mem_rdata);
  assign hit     = !op_q && (id_q != 16'h0) && (rd_hdr.id == id_q);
  assign last_dw = (dw_q == reg_cnt - SIZE_W'(1));

  ecap_ptr_check u_ptr (
    .ptr (rd_hdr.nxt),
    .ok  (nxt_ok)
  );

  ecap_region_calc #(.SIZE_W(SIZE_W)) u_region (
    .base     (off_q),
    .len      (size_q),
    .ok       (reg_ok),
    .first_dw (reg_first),
    .n_dw     (reg_cnt),
    .tail_be  (reg_tail_be)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      plane_q     <= PL_WMASK;
      op_q        <= 1'b0;
      id_q        <= '0;
      ver_q       <= '0;
      off_q       <= '0;
      size_q      <= '0;
      cur_q       <= '0;
      prv_q       <= '0;
      head_q      <= 1'b0;
      steps_q     <= '0;
      dw_q        <= '0;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      match_q     <= '0;
      prev_q      <= '0;
      mem_req_q   <= 1'b0;
      mem_we_q    <= 1'b0;
      mem_plane_q <= '0;
      mem_addr_q  <= '0;
      mem_be_q    <= '0;
      mem_wdata_q <= '0;
    end else begin
      mem_req_q <= 1'b0;
      mem_we_q  <= 1'b0;
      done_q    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_start) begin
            op_q    <= cmd_op;
            id_q    <= cmd_id;
            ver_q   <= cmd_ver;
            off_q   <= cmd_off;
            size_q  <= cmd_size;
            busy_q  <= 1'b1;
            err_q   <= 1'b0;
            match_q <= '0;
            prev_q  <= '0;
            state   <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (!op_q || reg_ok) begin
            mem_req_q   <= 1'b1;
            mem_plane_q <= PL_CFG;
            mem_addr_q  <= HEAD_DW;
            mem_be_q    <= 4'hF;
            cur_q       <= LIST_HEAD;
            prv_q       <= '0;
            head_q      <= 1'b1;
            steps_q     <= '0;
            state       <= ST_WAIT;
          end else begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            err_q  <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          state <= ST_DATA;
        end
        ST_DATA: begin
          if (op_q && head_q && (off_q == LIST_HEAD)) begin
            mem_req_q   <= 1'b1;
            mem_we_q    <= 1'b1;
            mem_plane_q <= PL_CFG;
            mem_addr_q  <= HEAD_DW;
            mem_be_q    <= 4'hF;
            mem_wdata_q <= {rd_hdr.nxt, ver_q, id_q};
            plane_q     <= PL_WMASK;
            dw_q        <= '0;
            state       <= ST_FILL;
          end else if (head_q && (mem_rdata == 32'h0)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            err_q  <= op_q;
            state  <= ST_IDLE;
          end else if (hit) begin
            match_q <= cur_q;
            prev_q  <= prv_q;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            state   <= ST_IDLE;
          end else if (rd_hdr.nxt == 12'h0) begin
            if (!op_q) begin
              prev_q <= cur_q;
              busy_q <= 1'b0;
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              mem_req_q   <= 1'b1;
              mem_we_q    <= 1'b1;
              mem_plane_q <= PL_CFG;
              mem_addr_q  <= cur_q[11:2];
              mem_be_q    <= 4'hF;
              mem_wdata_q <= {off_q, mem_rdata[19:0]};
              state       <= ST_NEWHDR;
            end
          end else if (!nxt_ok || (steps_q == STEP_W'(MAX_STEPS - 1))) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            err_q  <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            prv_q       <= cur_q;
            cur_q       <= rd_hdr.nxt;
            head_q      <= 1'b0;
            steps_q     <= steps_q + STEP_W'(1);
            mem_req_q   <= 1'b1;
            mem_plane_q <= PL_CFG;
            mem_addr_q  <= rd_hdr.nxt[11:2];
            state       <= ST_WAIT;
          end
        end
        ST_NEWHDR: begin
          mem_req_q   <= 1'b1;
          mem_we_q    <= 1'b1;
          mem_plane_q <= PL_CFG;
          mem_addr_q  <= off_q[11:2];
          mem_be_q    <= 4'hF;
          mem_wdata_q <= {12'h0, ver_q, id_q};
          plane_q     <= PL_WMASK;
          dw_q        <= '0;
          state       <= ST_FILL;
        end
        ST_FILL: begin
          mem_req_q   <= 1'b1;
          mem_we_q    <= 1'b1;
          mem_plane_q <= plane_q;
          mem_addr_q  <= reg_first + DW_AW'(dw_q);
          mem_be_q    <= last_dw ? reg_tail_be : 4'hF;
          mem_wdata_q <= (plane_q == PL_CHECK) ? 32'hFFFF_FFFF : 32'h0;
          if (last_dw) begin
            dw_q <= '0;
            if (plane_q == PL_CHECK) begin
              state <= ST_FIN;
            end else begin
              plane_q <= plane_e'(2'(plane_q) + 2'd1);
            end
          end else begin
            dw_q <= dw_q + SIZE_W'(1);
          end
        end
        ST_FIN: begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign err       = err_q;
  assign match_off = match_q;
  assign prev_off  = prev_q;
  assign mem_req   = mem_req_q;
  assign mem_we    = mem_we_q;
  assign mem_plane = mem_plane_q;
  assign mem_addr  = mem_addr_q;
  assign mem_be    = mem_be_q;
  assign mem_wdata = mem_wdata_q;

endmodule

// File: rtl/ecap_walker_chk.sv
module ecap_walker_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [11:0] match_off,
  input logic        mem_req,
  input logic        mem_we,
  input logic [1:0]  mem_plane,
  input logic [9:0]  mem_addr,
  input logic        op_append
);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R12
  quiet_port_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  // R5
  find_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> op_append);

  // R11
  mask_region_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && (mem_plane != 2'd0)) |-> (mem_addr >= 10'h040));

  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done);

  // R2
  hit_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (match_off[1:0] == 2'b00));

endmodule

bind ecap_walker ecap_walker_chk u_ecap_walker_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .match_off (match_off),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_plane (mem_plane),
  .mem_addr  (mem_addr),
  .op_append (op_q)
);

// File: tb/test_ecap_walker.sv
`timescale 1ns/1ps
module test_ecap_walker;

  localparam int SIZE_W = 13;
  localparam int WD_LIMIT = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_start = 1'b0;
  logic              cmd_op = 1'b0;
  logic [15:0]       cmd_id = '0;
  logic [3:0]        cmd_ver = '0;
  logic [11:0]       cmd_off = '0;
  logic [SIZE_W-1:0] cmd_size = '0;
  logic              busy, done, err;
  logic [11:0]       match_off, prev_off;
  logic              mem_req, mem_we;
  logic [1:0]        mem_plane;
  logic [9:0]        mem_addr;
  logic [3:0]        mem_be;
  logic [31:0]       mem_wdata;
  logic [31:0]       mem_rdata = '0;

  logic [31:0] mem [0:4095];
  logic        bd_we = 1'b0;
  logic        bd_clr = 1'b0;
  int          bd_idx = 0;
  logic [31:0] bd_data = '0;
  int          wr_count = 0;
  int          done_count = 0;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ecap_walker #(.MAX_STEPS(1024), .SIZE_W(SIZE_W)) i_ecap_walker (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_id(cmd_id), .cmd_ver(cmd_ver), .cmd_off(cmd_off), .cmd_size(cmd_size),
    .busy(busy), .done(done), .err(err), .match_off(match_off),
    .prev_off(prev_off), .mem_req(mem_req), .mem_we(mem_we),
    .mem_plane(mem_plane), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (bd_clr) begin
      for (int i = 0; i < 4096; i++) mem[i] <= 32'h0;
    end else if (bd_we) begin
      mem[bd_idx] <= bd_data;
    end else if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[{mem_plane, mem_addr}][8*b +: 8] <= mem_wdata[8*b +: 8];
        wr_count <= wr_count + 1;
      end else begin
        mem_rdata <= mem[{mem_plane, mem_addr}];
      end
    end
    if (done) done_count <= done_count + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input int idx, input logic [31:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_idx = idx; bd_data = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic wipe();
    @(negedge clk);
    bd_clr = 1'b1;
    @(negedge clk);
    bd_clr = 1'b0;
  endtask

  task automatic run(input logic op, input logic [15:0] id, input logic [3:0] ver,
                     input logic [11:0] off, input int size);
    int t;
    @(negedge clk);
    cmd_op = op; cmd_id = id; cmd_ver = ver; cmd_off = off;
    cmd_size = SIZE_W'(size); cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R12: actual no done expected done");
    end
  endtask

  // id, expected match offset, expected previous offset
  localparam logic [39:0] FIND_VEC [0:5] = '{
    {16'h0001, 12'h100, 12'h000},
    {16'h000B, 12'h140, 12'h100},
    {16'h0010, 12'h200, 12'h140},
    {16'h0023, 12'h000, 12'h200},
    {16'h0000, 12'h000, 12'h200},
    {16'hFFFF, 12'h000, 12'h200}
  };

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int w0, d0;
    repeat (3) @(negedge clk);
    wipe();
    rst = 1'b0;
    @(negedge clk);
    check("R12 reset busy", {31'h0, busy}, 32'h0);
    check("R12 reset done", {31'h0, done}, 32'h0);
    check("R12 reset mem_req", {31'h0, mem_req}, 32'h0);

    // R1 empty chain
    run(1'b0, 16'h0001, 4'h0, 12'h0, 0);
    check("R1 match", {20'h0, match_off}, 32'h0);
    check("R1 prev", {20'h0, prev_off}, 32'h0);
    check("R1 err", {31'h0, err}, 32'h0);

    // R2 R3 R4 table walk over a three-header chain
    poke(12'h040, 32'h1401_0001);
    poke(12'h050, 32'h2002_000B);
    poke(12'h080, 32'h0001_0010);
    w0 = wr_count;
    for (int i = 0; i < 6; i++) begin
      run(1'b0, FIND_VEC[i][39:24], 4'h0, 12'h0, 0);
      check("R2/R3/R4 match", {20'h0, match_off}, {20'h0, FIND_VEC[i][23:12]});
      check("R2/R3/R4 prev", {20'h0, prev_off}, {20'h0, FIND_VEC[i][11:0]});
      check("R2/R3/R4 err", {31'h0, err}, 32'h0);
    end
    check("R5 no writes on find", wr_count, w0);

    // R6 bad pointers
    poke(12'h040, 32'h1421_0001);
    run(1'b0, 16'h0009, 4'h0, 12'h0, 0);
    check("R6 misaligned", {31'h0, err}, 32'h1);
    poke(12'h040, 32'h0C01_0001);
    run(1'b0, 16'h0009, 4'h0, 12'h0, 0);
    check("R6 below head", {31'h0, err}, 32'h1);
    poke(12'h040, 32'hFFC1_0001);
    run(1'b0, 16'h0009, 4'h0, 12'h0, 0);
    check("R6 above limit", {31'h0, err}, 32'h1);

    // R7 self loop
    poke(12'h040, 32'h1001_0001);
    run(1'b0, 16'h0005, 4'h0, 12'h0, 0);
    check("R7 loop err", {31'h0, err}, 32'h1);

    // R8 append at head keeps stored pointer
    wipe();
    poke(12'h040, 32'h1801_0001);
    poke(1024 + 12'h040, 32'hFFFF_FFFF);
    poke(2048 + 12'h041, 32'hFFFF_FFFF);
    w0 = wr_count;
    run(1'b1, 16'h0022, 4'h2, 12'h100, 8);
    check("R8 err", {31'h0, err}, 32'h0);
    check("R8 head", mem[12'h040], 32'h1802_0022);
    check("R11 wmask head", mem[1024 + 12'h040], 32'h0);
    check("R11 w1c head", mem[2048 + 12'h041], 32'h0);
    check("R11 check head", mem[3072 + 12'h041], 32'hFFFF_FFFF);
    check("R8 write count", wr_count - w0, 7);

    // R9 R11 append mid-space with partial last dword
    wipe();
    poke(12'h040, 32'h1401_0001);
    poke(12'h050, 32'h0002_000B);
    for (int p = 1; p < 4; p++)
      for (int d = 12'h0C0; d < 12'h0C4; d++) poke(p * 1024 + d, 32'hA5A5_A5A5);
    w0 = wr_count;
    run(1'b1, 16'h0033, 4'h1, 12'h300, 10);
    check("R9 err", {31'h0, err}, 32'h0);
    check("R9 tail relinked", mem[12'h050], 32'h3002_000B);
    check("R9 new header", mem[12'h0C0], 32'h0001_0033);
    check("R11 wmask full", mem[1024 + 12'h0C1], 32'h0);
    check("R11 wmask partial", mem[1024 + 12'h0C2], 32'hA5A5_0000);
    check("R11 w1c partial", mem[2048 + 12'h0C2], 32'hA5A5_0000);
    check("R11 check partial", mem[3072 + 12'h0C2], 32'hA5A5_FFFF);
    check("R11 check full", mem[3072 + 12'h0C0], 32'hFFFF_FFFF);
    check("R11 beyond region", mem[1024 + 12'h0C3], 32'hA5A5_A5A5);
    check("R9 write count", wr_count - w0, 11);
    run(1'b0, 16'h0033, 4'h0, 12'h0, 0);
    check("R9 find new match", {20'h0, match_off}, 32'h300);
    check("R9 find new prev", {20'h0, prev_off}, 32'h140);

    // R10 refused appends
    w0 = wr_count;
    run(1'b1, 16'h0044, 4'h1, 12'h300, 4);
    check("R10 short size", {31'h0, err}, 32'h1);
    run(1'b1, 16'h0044, 4'h1, 12'hFF8, 8);
    check("R10 reaches top", {31'h0, err}, 32'h1);
    run(1'b1, 16'h0044, 4'h1, 12'h302, 8);
    check("R10 unaligned", {31'h0, err}, 32'h1);
    run(1'b1, 16'h0044, 4'h1, 12'h0F0, 8);
    check("R10 below head", {31'h0, err}, 32'h1);
    wipe();
    run(1'b1, 16'h0044, 4'h1, 12'h300, 8);
    check("R10 empty chain", {31'h0, err}, 32'h1);
    check("R10 no writes", wr_count, w0);

    // R12 start while busy is ignored
    poke(12'h040, 32'h0001_0001);
    d0 = done_count;
    @(negedge clk);
    cmd_op = 1'b1; cmd_id = 16'h0055; cmd_ver = 4'h3; cmd_off = 12'h400;
    cmd_size = SIZE_W'(16); cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    check("R12 busy after start", {31'h0, busy}, 32'h1);
    @(negedge clk);
    @(negedge clk);
    cmd_op = 1'b0; cmd_id = 16'h0001; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    repeat (80) @(negedge clk);
    check("R12 single done", done_count - d0, 1);
    check("R12 idle after", {31'h0, busy}, 32'h0);
    check("R12 append kept", mem[12'h100], 32'h0003_0055);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule